// File: doc/BRIEF.md
# Contiguous Memory Bank Address Decoder

This block turns a flat physical byte address into a bank select and a byte offset inside that bank, for a memory system built from ten RAM banks. Two banks belong to the memory fitted on the board and two to each of four module sockets. Each bank is given a raw populated size through a small configuration write port. The decoder stacks the banks back to back in bank order, starting at address zero. Each bank starts on the byte right after the last populated byte of the bank before it, so installed memory forms one region with no holes. Addresses at or past the end of that region are flagged as misses.

A mode register sets the largest bank size the map accepts, either the low or the high limit. A bank whose raw size is larger than the active limit is mapped only up to the limit. The mode register can also ask each pair of banks to run interleaved. In that case both banks of the pair share one region, and alternate half-words of every bus word land in the two banks. A pair only interleaves when both of its banks are populated with the same effective size. A lone bank or a mismatched pair is mapped linearly.

Requests are decoded with one cycle of latency, and the result is qualified by an output valid flag.

Top module: `mem_bank_decoder`

## Requirements
- R1: After reset, outValid is 0, every raw bank size is 0 and the mode register is 0, so every address presented afterwards is reported as a miss.
- R2: A write with cfgWrEn high and cfgSel below NUM_BANKS loads the low SIZE_W bits of cfgData as that bank's raw size, in units of 2^UNIT_SHIFT bytes. A write with cfgSel all ones loads the mode register: bit 0 selects the high size limit, and bit k+1 requests interleave for pair k (banks 2k and 2k+1). Writes to any other select value, and any cycle with cfgWrEn low, change nothing. A write is in effect for requests presented from the next cycle on.
- R3: The effective size of a bank is the smaller of its raw size and the active limit. The limit is LIMIT_LO when mode bit 0 is 0 and LIMIT_HI when it is 1.
- R4: Bank i occupies the unit range [S_i, S_i + E_i), where E_i is its effective size and S_i is the sum of E_j for all j < i. A bank of effective size 0 is never selected.
- R5: For an address inside a linearly mapped bank i, outBank is i and outOff is the address minus S_i * 2^UNIT_SHIFT.
- R6: An address at or above the total effective size times 2^UNIT_SHIFT gives outMiss 1, with outSel, outBank and outOff all 0.
- R7: An interleaved pair k occupies [S_2k, S_2k + 2*E_2k) as one region. Let o be the address minus S_2k * 2^UNIT_SHIFT. Bit LANE_BIT of o picks the bank: 0 selects bank 2k and 1 selects bank 2k+1. outOff is o with bit LANE_BIT removed: (o >> (LANE_BIT+1)) << LANE_BIT, plus the low LANE_BIT bits of o.
- R8: An interleave request for a pair whose banks are not both nonzero and equal in effective size is ignored, and both banks are mapped linearly as in R5.
- R9: A request sampled with reqValid high at a clock edge gives outValid 1 and its decoded outputs right after that edge.
- R10: A clock edge with reqValid low drives outValid to 0 and leaves outMiss, outBank, outSel and outOff unchanged.
- R11: Every valid hit has exactly one bit set in outSel, and that bit is the one at position outBank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | SEL_W | Register select: bank index, or all ones for the mode register |
| cfgData | input | CFG_W | Configuration write data |
| reqValid | input | 1 | Address request valid |
| reqAddr | input | ADDR_W | Physical byte address to decode |
| outValid | output | 1 | Decoded result valid |
| outMiss | output | 1 | Address is past the installed memory |
| outBank | output | BANK_W | Index of the selected bank |
| outSel | output | NUM_BANKS | One-hot bank select |
| outOff | output | ADDR_W | Byte offset inside the selected bank |

## Verification
The bench sweeps every address of a small instance across configurations that include empty banks in the middle of the stack and raw sizes above the low limit. These catch a design that leaves a hole for an empty bank, or that stacks banks by their raw size instead of the clipped size. That design would shift every later bank and report the wrong bank or offset. Pairs with equal, unequal and one-sided population are each asked to interleave. A decoder that interleaves a mismatched pair sends bytes to a bank that does not hold them, and one that gets the lane bit or the offset compaction wrong scrambles data inside the pair. Writes to unused select values, data presented with the strobe low, and idle request cycles are each followed by a full sweep or a hold check, so that corrupted configuration or drifting outputs show up at the ports.

// File: rtl/mem_bank_decoder_pkg.sv
`timescale 1ns/1ps
package mem_bank_decoder_pkg;

  // Strobes from the control side to the datapath side
  typedef struct packed {
    logic sizeWr;   // load one bank's raw size
    logic modeWr;   // load limit and interleave requests
    logic capture;  // register a new decode result
  } dec_strobe_t;

endpackage

// File: rtl/mem_bank_decoder_ctrl.sv
`timescale 1ns/1ps
module mem_bank_decoder_ctrl
  import mem_bank_decoder_pkg::*;
#(
  parameter int NUM_BANKS = 10,
  parameter int SEL_W     = 4
) (
  input  logic             cfgWrEn,
  input  logic [SEL_W-1:0] cfgSel,
  input  logic             reqValid,
  output dec_strobe_t      strobes
);

  localparam logic [SEL_W-1:0] MODE_SEL  = '1;
  localparam logic [SEL_W-1:0] BANK_LAST = SEL_W'(NUM_BANKS - 1);

  always_comb begin
    strobes.sizeWr  = cfgWrEn && (cfgSel <= BANK_LAST);
    strobes.modeWr  = cfgWrEn && (cfgSel == MODE_SEL);
    strobes.capture = reqValid;
  end

endmodule

// File: rtl/mem_bank_decoder_map.sv
`timescale 1ns/1ps
module mem_bank_decoder_map
  import mem_bank_decoder_pkg::*;
#(
  parameter int NUM_BANKS = 10,
  parameter int SIZE_W    = 8,
  parameter int CFG_W     = 8,
  parameter int SEL_W     = 4,
  parameter int CMP_W     = 12,
  parameter int LIMIT_LO  = 32,
  parameter int LIMIT_HI  = 64
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  dec_strobe_t                         strobes,
  input  logic [SEL_W-1:0]                    cfgSel,
  input  logic [CFG_W-1:0]                    cfgData,
  output logic [NUM_BANKS-1:0][CMP_W-1:0]     startU,
  output logic [NUM_BANKS-1:0][CMP_W-1:0]     endU,
  output logic [NUM_BANKS/2-1:0]              ilvOn
);

  localparam int NUM_PAIRS = NUM_BANKS / 2;
  localparam logic [SIZE_W-1:0] LIM_LO = SIZE_W'(LIMIT_LO);
  localparam logic [SIZE_W-1:0] LIM_HI = SIZE_W'(LIMIT_HI);

  logic [NUM_BANKS-1:0][SIZE_W-1:0] rawSize;
  logic [NUM_BANKS-1:0][SIZE_W-1:0] effSize;
  logic                             bigBanks;
  logic [NUM_PAIRS-1:0]             ilvReq;
  logic [SIZE_W-1:0]                activeLim;
  logic [CMP_W-1:0]                 runSum;

  // Raw size registers, one per bank
  for (genvar g = 0; g < NUM_BANKS; g++) begin : gSizeReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rawSize[g] <= '0;
      end else if (strobes.sizeWr && (cfgSel == SEL_W'(g))) begin
        rawSize[g] <= cfgData[SIZE_W-1:0];
      end
    end
  end

  // Mode register: size limit and per-pair interleave requests
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bigBanks <= 1'b0;
      ilvReq   <= '0;
    end else if (strobes.modeWr) begin
      bigBanks <= cfgData[0];
      ilvReq   <= cfgData[NUM_PAIRS:1];
    end
  end

  assign activeLim = bigBanks ? LIM_HI : LIM_LO;

  // Clip each bank to the active limit
  for (genvar g = 0; g < NUM_BANKS; g++) begin : gClip
    assign effSize[g] = (rawSize[g] > activeLim) ? activeLim : rawSize[g];
  end

  // Stack banks back to back by effective size
  always_comb begin
    runSum = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      startU[i] = runSum;
      runSum    = runSum + CMP_W'(effSize[i]);
      endU[i]   = runSum;
    end
  end

  // A pair interleaves only with two equal, nonzero halves
  for (genvar p = 0; p < NUM_PAIRS; p++) begin : gPair
    assign ilvOn[p] = ilvReq[p]
                   && (effSize[2*p] != '0)
                   && (effSize[2*p] == effSize[2*p+1]);
  end

endmodule

// File: rtl/mem_bank_decoder_dp.sv
`timescale 1ns/1ps
module mem_bank_decoder_dp
  import mem_bank_decoder_pkg::*;
#(
  parameter int NUM_BANKS  = 10,
  parameter int ADDR_W     = 32,
  parameter int UNIT_SHIFT = 20,
  parameter int CMP_W      = 12,
  parameter int BANK_W     = 4,
  parameter int LANE_BIT   = 1
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  dec_strobe_t                     strobes,
  input  logic [ADDR_W-1:0]               reqAddr,
  input  logic [NUM_BANKS-1:0][CMP_W-1:0] startU,
  input  logic [NUM_BANKS-1:0][CMP_W-1:0] endU,
  input  logic [NUM_BANKS/2-1:0]          ilvOn,
  output logic                            outValid,
  output logic                            outMiss,
  output logic [BANK_W-1:0]               outBank,
  output logic [NUM_BANKS-1:0]            outSel,
  output logic [ADDR_W-1:0]               outOff
);

  localparam int NUM_PAIRS = NUM_BANKS / 2;
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << LANE_BIT) - 1);

  logic [CMP_W-1:0]      uAddr;
  logic [NUM_BANKS-1:0]  linHit;
  logic [NUM_PAIRS-1:0]  pairHit;
  logic                  nextMiss;
  logic [BANK_W-1:0]     nextBank;
  logic [NUM_BANKS-1:0]  nextSel;
  logic [ADDR_W-1:0]     nextOff;
  logic [ADDR_W-1:0]     rel;

  function automatic logic [ADDR_W-1:0] toByte(input logic [CMP_W-1:0] u);
    return ADDR_W'(u) << UNIT_SHIFT;
  endfunction

  assign uAddr = CMP_W'(reqAddr >> UNIT_SHIFT);

  // Linear hit per bank, suppressed where the pair interleaves
  for (genvar g = 0; g < NUM_BANKS; g++) begin : gLin
    assign linHit[g] = !ilvOn[g/2] && (uAddr >= startU[g]) && (uAddr < endU[g]);
  end

  // Interleaved pair hit spans both banks' ranges
  for (genvar p = 0; p < NUM_PAIRS; p++) begin : gIlv
    assign pairHit[p] = ilvOn[p] && (uAddr >= startU[2*p]) && (uAddr < endU[2*p+1]);
  end

  assign nextMiss = (uAddr >= endU[NUM_BANKS-1]);

  always_comb begin
    nextSel  = '0;
    nextBank = '0;
    nextOff  = '0;
    rel      = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (linHit[i]) begin
        nextSel[i] = 1'b1;
        nextBank   = BANK_W'(i);
        nextOff    = reqAddr - toByte(startU[i]);
      end
    end
    for (int p = 0; p < NUM_PAIRS; p++) begin
      if (pairHit[p]) begin
        rel     = reqAddr - toByte(startU[2*p]);
        nextOff = ((rel >> (LANE_BIT + 1)) << LANE_BIT) | (rel & LOW_MASK);
        if (rel[LANE_BIT]) begin
          nextSel[2*p+1] = 1'b1;
          nextBank       = BANK_W'(2*p + 1);
        end else begin
          nextSel[2*p]   = 1'b1;
          nextBank       = BANK_W'(2*p);
        end
      end
    end
  end

  // Result register: valid pulses per request, data holds otherwise
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outMiss  <= 1'b0;
      outBank  <= '0;
      outSel   <= '0;
      outOff   <= '0;
    end else begin
      outValid <= strobes.capture;
      if (strobes.capture) begin
        outMiss <= nextMiss;
        outBank <= nextMiss ? '0 : nextBank;
        outSel  <= nextMiss ? '0 : nextSel;
        outOff  <= nextMiss ? '0 : nextOff;
      end
    end
  end

endmodule

// File: rtl/mem_bank_decoder.sv
`timescale 1ns/1ps
module mem_bank_decoder
  import mem_bank_decoder_pkg::*;
#(
  parameter int NUM_BANKS  = 10,
  parameter int ADDR_W     = 32,
  parameter int UNIT_SHIFT = 20,
  parameter int SIZE_W     = 8,
  parameter int CFG_W      = 8,
  parameter int LIMIT_LO   = 32,
  parameter int LIMIT_HI   = 64,
  parameter int LANE_BIT   = 1,
  localparam int BANK_W    = $clog2(NUM_BANKS),
  localparam int SEL_W     = $clog2(NUM_BANKS + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWrEn,
  input  logic [SEL_W-1:0]     cfgSel,
  input  logic [CFG_W-1:0]     cfgData,
  input  logic                 reqValid,
  input  logic [ADDR_W-1:0]    reqAddr,
  output logic                 outValid,
  output logic                 outMiss,
  output logic [BANK_W-1:0]    outBank,
  output logic [NUM_BANKS-1:0] outSel,
  output logic [ADDR_W-1:0]    outOff
);

  localparam int UNIT_W = ADDR_W - UNIT_SHIFT;
  localparam int SUM_W  = SIZE_W + BANK_W;
  localparam int CMP_W  = (SUM_W > UNIT_W) ? SUM_W : UNIT_W;

  dec_strobe_t                     strobes;
  logic [NUM_BANKS-1:0][CMP_W-1:0] startU;
  logic [NUM_BANKS-1:0][CMP_W-1:0] endU;
  logic [NUM_BANKS/2-1:0]          ilvOn;

  mem_bank_decoder_ctrl #(
    .NUM_BANKS(NUM_BANKS),
    .SEL_W    (SEL_W)
  ) uCtrl (
    .cfgWrEn (cfgWrEn),
    .cfgSel  (cfgSel),
    .reqValid(reqValid),
    .strobes (strobes)
  );

  mem_bank_decoder_map #(
    .NUM_BANKS(NUM_BANKS),
    .SIZE_W   (SIZE_W),
    .CFG_W    (CFG_W),
    .SEL_W    (SEL_W),
    .CMP_W    (CMP_W),
    .LIMIT_LO (LIMIT_LO),
    .LIMIT_HI (LIMIT_HI)
  ) uMap (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .cfgSel (cfgSel),
    .cfgData(cfgData),
    .startU (startU),
    .endU   (endU),
    .ilvOn  (ilvOn)
  );

  mem_bank_decoder_dp #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W),
    .UNIT_SHIFT(UNIT_SHIFT),
    .CMP_W     (CMP_W),
    .BANK_W    (BANK_W),
    .LANE_BIT  (LANE_BIT)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .reqAddr (reqAddr),
    .startU  (startU),
    .endU    (endU),
    .ilvOn   (ilvOn),
    .outValid(outValid),
    .outMiss (outMiss),
    .outBank (outBank),
    .outSel  (outSel),
    .outOff  (outOff)
  );

endmodule

// File: rtl/mem_bank_decoder_chk.sv
`timescale 1ns/1ps
module mem_bank_decoder_chk #(
  parameter int NUM_BANKS = 10,
  parameter int ADDR_W    = 32,
  parameter int BANK_W    = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic                 outValid,
  input logic                 outMiss,
  input logic [BANK_W-1:0]    outBank,
  input logic [NUM_BANKS-1:0] outSel,
  input logic [ADDR_W-1:0]    outOff
);

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rstN |-> !outValid);

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> outValid);

  // R10
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !outValid);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> ($stable(outMiss) && $stable(outBank) && $stable(outSel) && $stable(outOff)));

  // R6
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outMiss) |-> (outSel == '0 && outOff == '0 && outBank == '0));

  // R11
  hit_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outMiss) |-> ($countones(outSel) == 1 && outSel[outBank]));

endmodule

bind mem_bank_decoder mem_bank_decoder_chk #(
  .NUM_BANKS(NUM_BANKS),
  .ADDR_W   (ADDR_W),
  .BANK_W   (BANK_W)
) chk (
  .clk     (clk),
  .rstN    (rstN),
  .reqValid(reqValid),
  .outValid(outValid),
  .outMiss (outMiss),
  .outBank (outBank),
  .outSel  (outSel),
  .outOff  (outOff)
);

// File: tb/tb_mem_bank_decoder.sv
`timescale 1ns/1ps
module tb_mem_bank_decoder;

  localparam int NB   = 10;
  localparam int AW   = 12;
  localparam int US   = 4;
  localparam int SW   = 6;
  localparam int LLO  = 4;
  localparam int LHI  = 8;
  localparam int NADR = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWrEn = 1'b0;
  logic [3:0]    cfgSel = '0;
  logic [7:0]    cfgData = '0;
  logic          reqValid = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic          outValid;
  logic          outMiss;
  logic [3:0]    outBank;
  logic [NB-1:0] outSel;
  logic [AW-1:0] outOff;

  int checks = 0;
  int errors = 0;

  int raw [NB];
  bit big;
  bit ilv [NB/2];

  always #10 clk = ~clk;

  mem_bank_decoder #(
    .NUM_BANKS(NB), .ADDR_W(AW), .UNIT_SHIFT(US), .SIZE_W(SW),
    .CFG_W(8), .LIMIT_LO(LLO), .LIMIT_HI(LHI), .LANE_BIT(1)
  ) dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgData(cfgData),
    .reqValid(reqValid), .reqAddr(reqAddr), .outValid(outValid), .outMiss(outMiss),
    .outBank(outBank), .outSel(outSel), .outOff(outOff)
  );

  function automatic int effOf(int i);
    int lim = big ? LHI : LLO;
    return (raw[i] > lim) ? lim : raw[i];
  endfunction

  // Expected decode from the requirements
  function automatic void model(input int a, output bit miss, output int bank,
                                output int off, output string tag);
    int eff [NB];
    int st [NB];
    bit on [NB/2];
    int acc = 0;
    int u = a >> US;
    for (int i = 0; i < NB; i++) begin
      eff[i] = effOf(i);
      st[i]  = acc;
      acc   += eff[i];
    end
    for (int p = 0; p < NB/2; p++)
      on[p] = ilv[p] && eff[2*p] != 0 && eff[2*p] == eff[2*p+1];
    miss = (u >= acc);
    bank = 0;
    off  = 0;
    tag  = "R6";
    if (!miss) begin
      for (int i = 0; i < NB; i++) begin
        if (on[i/2]) begin
          if (i % 2 == 0 && u >= st[i] && u < st[i] + 2*eff[i]) begin
            int rel = a - st[i] * (1 << US);
            bank = i + ((rel >> 1) & 1);
            off  = (rel >> 2) * 2 + (rel & 1);
            tag  = "R7";
          end
        end else if (u >= st[i] && u < st[i] + eff[i]) begin
          bank = i;
          off  = a - st[i] * (1 << US);
          tag  = ilv[i/2] ? "R8" : "R5";
        end
      end
    end
  endfunction

  task automatic checkAddr(input string grp, input int a);
    bit eMiss; int eBank; int eOff; string tag;
    bit bad;
    model(a, eMiss, eBank, eOff, tag);
    checks++;
    bad = (outValid !== 1'b1) || (outMiss !== eMiss);
    if (eMiss)
      bad = bad || (outSel !== '0) || (outOff !== '0) || (outBank !== '0);
    else
      bad = bad || (outBank !== 4'(eBank)) || (outSel !== (NB'(1) << eBank))
                || (outOff !== AW'(eOff));
    if (bad) begin
      errors++;
      $display("FAIL %s/%s/R9/R11 addr=%0d: valid=%0b miss=%0b bank=%0d sel=%b off=%0d, expected valid=1 miss=%0b bank=%0d sel=%b off=%0d",
               grp, tag, a, outValid, outMiss, outBank, outSel, outOff,
               eMiss, eMiss ? 0 : eBank, eMiss ? NB'(0) : (NB'(1) << eBank), eMiss ? 0 : eOff);
    end
  endtask

  task automatic sweep(input string grp);
    for (int a = 0; a < NADR; a++) begin
      @(negedge clk);
      reqValid = 1'b1;
      reqAddr  = AW'(a);
      @(negedge clk);
      checkAddr(grp, a);
    end
    reqValid = 1'b0;
  endtask

  // R2: a real write, mirrored into the model when the select is decoded
  task automatic writeCfg(input int sel, input int d);
    @(negedge clk);
    cfgWrEn = 1'b1;
    cfgSel  = 4'(sel);
    cfgData = 8'(d);
    @(negedge clk);
    cfgWrEn = 1'b0;
    if (sel < NB) raw[sel] = d & ((1 << SW) - 1);
    if (sel == 15) begin
      big = d[0];
      for (int p = 0; p < NB/2; p++) ilv[p] = d[p+1];
    end
  endtask

  task automatic ghostWrite(input int sel, input int d);
    @(negedge clk);
    cfgWrEn = 1'b0;
    cfgSel  = 4'(sel);
    cfgData = 8'(d);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] hBank; logic [AW-1:0] hOff; logic hMiss; logic [NB-1:0] hSel;
    for (int i = 0; i < NB; i++) raw[i] = 0;
    big = 0;
    for (int p = 0; p < NB/2; p++) ilv[p] = 0;

    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (outValid !== 1'b0 || outSel !== '0) begin
      errors++;
      $display("FAIL R1 reset: valid=%0b sel=%b, expected valid=0 sel=0", outValid, outSel);
    end
    rstN = 1'b1;
    sweep("R1");

    // R4 with empty banks mid-stack, R3 low limit clipping
    writeCfg(0, 4); writeCfg(1, 0); writeCfg(2, 8); writeCfg(3, 8); writeCfg(4, 3);
    writeCfg(5, 0); writeCfg(6, 2); writeCfg(7, 5); writeCfg(8, 0); writeCfg(9, 1);
    sweep("R4");

    // R3: high limit
    writeCfg(15, 8'b0000_0001);
    sweep("R3");

    // R7 equal pair, R8 one-sided and unequal pairs
    writeCfg(15, 8'b0001_0111);
    sweep("R7");

    // R2: unused selects and strobe-low data leave the map intact
    writeCfg(10, 8'hFF);
    writeCfg(12, 8'hFF);
    ghostWrite(2, 0);
    ghostWrite(15, 0);
    sweep("R2");

    // R8/R3: everything requested, low limit
    writeCfg(15, 8'b0011_1110);
    sweep("R8");

    // Full population, all pairs interleaved
    for (int i = 0; i < NB; i++) writeCfg(i, 8);
    writeCfg(15, 8'b0011_1111);
    sweep("R7");

    // R10: idle cycles hold the result and drop valid
    @(negedge clk);
    reqValid = 1'b1;
    reqAddr  = AW'(700);
    @(negedge clk);
    checkAddr("R10", 700);
    hBank = outBank; hOff = outOff; hMiss = outMiss; hSel = outSel;
    reqValid = 1'b0;
    reqAddr  = AW'(5);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      checks++;
      if (outValid !== 1'b0 || outBank !== hBank || outOff !== hOff
          || outMiss !== hMiss || outSel !== hSel) begin
        errors++;
        $display("FAIL R10 idle: valid=%0b bank=%0d off=%0d miss=%0b, expected valid=0 bank=%0d off=%0d miss=%0b",
                 outValid, outBank, outOff, outMiss, hBank, hOff, hMiss);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule